// File: doc/BRIEF.md
# Frame Workload Predictor

This block estimates how many cycles the next frame of a periodic job will take, so that a voltage and frequency controller can pick an operating point before the frame starts. After each frame the real cycle count is handed in. The block answers with a forecast for the following frame and with the signed miss of the forecast it had made for the frame that just finished.

A two-bit mode input selects one of three estimators. The first is a plain mean over the last N frames. The second is an exponential smoother whose decay is a right shift by a programmable amount. The third is a correction loop that adds a proportional, a windowed-integral and a windowed-difference term of past misses to the current forecast. All histories advance on every sample whatever the mode, so the mode can change between frames without a restart. Window lengths are powers of two, so every division is a shift. The three loop gains are small unsigned multipliers.

Top module: `wl_predictor`

## Requirements
- R1: After synchronous reset the outputs are: forecast 0, miss 0, `res_valid` 0, `warmup` 1 and `smp_ready` 1.
- R2: A sample is accepted on a clock edge where `smp_valid` and `smp_ready` are both high. `res_valid` is high right after that edge. While `res_valid` is high and `res_ready` is low, `smp_ready` is low, no sample is taken, and the forecast and miss hold. `res_valid` falls on the first edge with `res_ready` high and no new sample.
- R3: `miss` is the accepted cycle count minus the forecast that was on `forecast` when the sample was accepted. It is a signed two's-complement value of DW+1 bits.
- R4: With `mode` 0 the new forecast is floor(sum of the last N cycle counts, this one included, / N). Frames not yet seen count as 0.
- R5: With `mode` 1 the new forecast is the old forecast plus the miss, arithmetically shifted right by `ewa_shift`. The shift rounds toward minus infinity.
- R6: With `mode` 2 or 3 the new forecast is the old forecast plus three terms. The terms are kp times the miss, ki times (sum of the last WI misses, this one included) arithmetically shifted right by log2(WI), and kd times (this miss minus the miss WD frames earlier) arithmetically shifted right by log2(WD). Missing history counts as 0.
- R7: A forecast below 0 is output as 0, and one above 2^DW-1 is output as 2^DW-1.
- R8: After each accepted sample, `warmup` is 1 exactly when fewer samples have been accepted since reset than the window of the current mode. The windows are N for mode 0, 1 for mode 1, and max(WI,WD) for modes 2 and 3. `warmup` changes only when a sample is accepted.
- R9: Both histories take in every accepted sample in every mode, so after a mode change the new estimator works on the full past.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 2 | 0 mean, 1 exponential, 2/3 correction loop |
| ewa_shift | input | SHW | Decay shift of the exponential mode |
| kp | input | GW | Proportional gain |
| ki | input | GW | Integral gain |
| kd | input | GW | Difference gain |
| smp_valid | input | 1 | Cycle count offered |
| smp_ready | output | 1 | Cycle count can be taken |
| smp_cycles | input | DW | Measured cycles of the finished frame |
| res_valid | output | 1 | Forecast available |
| res_ready | input | 1 | Forecast consumed |
| forecast | output | DW | Predicted cycles of the next frame |
| miss | output | DW+1 | Signed miss of the previous forecast |
| warmup | output | 1 | Selected window not yet filled |

## Verification
The assertions check the handshake on every cycle: a result follows each accepted sample, results hold under back-pressure, and `warmup` moves only with a sample. They also check that the history fill counters stay bounded and move only on a write, and that a zero decay shift makes the exponential mode copy the input. The arithmetic of the three estimators, the zero-filled warm-up windows, both saturation limits and the effect of changing mode depend on long sample sequences. Only the bench's reference model, driven with directed and seeded random streams, can show those.

// File: rtl/wl_pkg.sv
package wl_pkg;
  typedef enum logic [1:0] {
    EST_MEAN = 2'd0,
    EST_EXP  = 2'd1,
    EST_LOOP = 2'd2,
    EST_LOOP_ALT = 2'd3
  } est_mode_e;
endpackage

// File: rtl/wl_history.sv
module wl_history #(
  parameter int DEPTH = 8,
  parameter int DW    = 17,
  parameter int NTAP  = 1,
  parameter int LAG0  = 8,
  parameter int LAG1  = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 we,
  input  logic [DW-1:0]        wdata,
  output logic [NTAP*DW-1:0]   taps
);
  localparam int AW = $clog2(DEPTH);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wptr;
  logic [AW:0]   fill;

  // storage without reset so it maps to distributed RAM
  always_ff @(posedge clk) begin
    if (we) mem[wptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr <= '0;
      fill <= '0;
    end else if (we) begin
      wptr <= wptr + 1'b1;
      if (fill != (AW+1)'(DEPTH)) fill <= fill + 1'b1;
    end
  end

  // each tap returns the entry LAG writes back, zero while not yet written
  for (genvar t = 0; t < NTAP; t++) begin : g_tap
    localparam int LAG = (t == 0) ? LAG0 : LAG1;
    localparam logic [AW-1:0] OFF = AW'(LAG % DEPTH);
    assign taps[t*DW +: DW] = (fill >= (AW+1)'(LAG)) ? mem[wptr - OFF] : '0;
  end

  // R9
  fill_bound_chk: assert property (@(posedge clk) disable iff (rst)
    fill <= (AW+1)'(DEPTH));
  // R9
  fill_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !we |=> $stable(fill));
endmodule

// File: rtl/wl_loop_corr.sv
module wl_loop_corr #(
  parameter int EW     = 17,
  parameter int IW     = 20,
  parameter int AW     = 28,
  parameter int GW     = 4,
  parameter int LOG_WI = 3,
  parameter int LOG_WD = 2
) (
  input  logic signed [EW-1:0] cur_err,
  input  logic signed [EW-1:0] err_wi,
  input  logic signed [EW-1:0] err_wd,
  input  logic signed [IW-1:0] isum,
  input  logic [GW-1:0]        kp,
  input  logic [GW-1:0]        ki,
  input  logic [GW-1:0]        kd,
  output logic signed [IW-1:0] isum_nxt,
  output logic signed [AW-1:0] corr
);
  logic signed [IW-1:0] cur_i, old_i, i_term;
  logic signed [EW:0]   cur_d, old_d, d_diff, d_term;
  logic signed [AW-1:0] p_x, i_x, d_x, kp_x, ki_x, kd_x;

  assign cur_i    = cur_err;
  assign old_i    = err_wi;
  assign isum_nxt = isum + cur_i - old_i;
  assign i_term   = isum_nxt >>> LOG_WI;

  assign cur_d  = cur_err;
  assign old_d  = err_wd;
  assign d_diff = cur_d - old_d;
  assign d_term = d_diff >>> LOG_WD;

  assign p_x  = cur_err;
  assign i_x  = i_term;
  assign d_x  = d_term;
  assign kp_x = $signed({1'b0, kp});
  assign ki_x = $signed({1'b0, ki});
  assign kd_x = $signed({1'b0, kd});

  assign corr = kp_x * p_x + ki_x * i_x + kd_x * d_x;
endmodule

// File: rtl/wl_predictor.sv
module wl_predictor #(
  parameter int DW  = 16,
  parameter int N   = 8,
  parameter int WI  = 8,
  parameter int WD  = 4,
  parameter int GW  = 4,
  parameter int SHW = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [1:0]           mode,
  input  logic [SHW-1:0]       ewa_shift,
  input  logic [GW-1:0]        kp,
  input  logic [GW-1:0]        ki,
  input  logic [GW-1:0]        kd,
  input  logic                 smp_valid,
  output logic                 smp_ready,
  input  logic [DW-1:0]        smp_cycles,
  output logic                 res_valid,
  input  logic                 res_ready,
  output logic [DW-1:0]        forecast,
  output logic signed [DW:0]   miss,
  output logic                 warmup
);
  import wl_pkg::*;

  localparam int EW     = DW + 1;
  localparam int LOG_N  = $clog2(N);
  localparam int LOG_WI = $clog2(WI);
  localparam int LOG_WD = $clog2(WD);
  localparam int D      = (WI > WD) ? WI : WD;
  localparam int WMAX   = (N > D) ? N : D;
  localparam int CW     = $clog2(WMAX + 1);
  localparam int SW     = DW + LOG_N;
  localparam int IW     = EW + LOG_WI;
  localparam int AW     = DW + GW + 12;
  localparam logic signed [AW-1:0] TOP_V = {{(AW-DW){1'b0}}, {DW{1'b1}}};

  est_mode_e md;
  assign md = est_mode_e'(mode);

  logic accept;
  assign smp_ready = !res_valid || res_ready;
  assign accept    = smp_valid && smp_ready;

  logic [SW-1:0]        ma_sum;
  logic signed [IW-1:0] isum;
  logic [CW-1:0]        cnt;

  // current miss
  logic signed [EW-1:0] err_c;
  assign err_c = $signed({1'b0, smp_cycles}) - $signed({1'b0, forecast});

  // histories
  logic [DW-1:0]   old_act;
  logic [2*EW-1:0] err_taps;

  wl_history #(.DEPTH(N), .DW(DW), .NTAP(1), .LAG0(N), .LAG1(N)) i_act_hist (
    .clk(clk), .rst(rst), .we(accept), .wdata(smp_cycles), .taps(old_act)
  );

  wl_history #(.DEPTH(D), .DW(EW), .NTAP(2), .LAG0(WI), .LAG1(WD)) i_err_hist (
    .clk(clk), .rst(rst), .we(accept), .wdata(err_c), .taps(err_taps)
  );

  // mean estimator
  logic [SW-1:0] ma_sum_nxt, ma_avg;
  assign ma_sum_nxt = ma_sum + SW'(smp_cycles) - SW'(old_act);
  assign ma_avg     = ma_sum_nxt >> LOG_N;

  // exponential estimator
  logic signed [EW-1:0] ewa_step;
  logic signed [AW-1:0] ewa_x, est_x;
  assign ewa_step = err_c >>> ewa_shift;
  assign ewa_x    = ewa_step;
  assign est_x    = $signed({{(AW-DW){1'b0}}, forecast});

  // correction loop
  logic signed [IW-1:0] isum_nxt;
  logic signed [AW-1:0] corr;

  wl_loop_corr #(.EW(EW), .IW(IW), .AW(AW), .GW(GW), .LOG_WI(LOG_WI), .LOG_WD(LOG_WD)) i_corr (
    .cur_err(err_c),
    .err_wi($signed(err_taps[EW-1:0])),
    .err_wd($signed(err_taps[2*EW-1:EW])),
    .isum(isum), .kp(kp), .ki(ki), .kd(kd),
    .isum_nxt(isum_nxt), .corr(corr)
  );

  // selection and clamp
  logic signed [AW-1:0] nxt;
  logic [DW-1:0]        nxt_sat;
  logic [CW-1:0]        cnt_nxt, win;

  always_comb begin
    case (md)
      EST_MEAN: nxt = $signed({{(AW-SW){1'b0}}, ma_avg});
      EST_EXP:  nxt = est_x + ewa_x;
      default:  nxt = est_x + corr;
    endcase
    if (nxt < 0)          nxt_sat = '0;
    else if (nxt > TOP_V) nxt_sat = '1;
    else                  nxt_sat = nxt[DW-1:0];
  end

  always_comb begin
    case (md)
      EST_MEAN: win = CW'(N);
      EST_EXP:  win = CW'(1);
      default:  win = CW'(D);
    endcase
    cnt_nxt = (cnt == CW'(WMAX)) ? cnt : cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      forecast  <= '0;
      miss      <= '0;
      warmup    <= 1'b1;
      res_valid <= 1'b0;
      ma_sum    <= '0;
      isum      <= '0;
      cnt       <= '0;
    end else begin
      if (accept) begin
        forecast  <= nxt_sat;
        miss      <= err_c;
        warmup    <= (cnt_nxt < win);
        res_valid <= 1'b1;
        ma_sum    <= ma_sum_nxt;
        isum      <= isum_nxt;
        cnt       <= cnt_nxt;
      end else if (res_ready) begin
        res_valid <= 1'b0;
      end
    end
  end

  // R2
  result_follows_chk: assert property (@(posedge clk) disable iff (rst)
    accept |=> res_valid);
  // R2
  result_hold_chk: assert property (@(posedge clk) disable iff (rst)
    res_valid && !res_ready |=> res_valid && $stable(forecast) && $stable(miss));
  // R5
  exp_copy_chk: assert property (@(posedge clk) disable iff (rst)
    accept && md == EST_EXP && ewa_shift == '0 |=> forecast == $past(smp_cycles));
  // R8
  warm_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !accept |=> $stable(warmup));
endmodule

// File: tb/test_wl_predictor.sv
module test_wl_predictor;
  localparam int DW = 16, N = 8, WI = 8, WD = 4, D = 8;
  localparam int LOG_N = 3, LOG_WI = 3, LOG_WD = 2;
  localparam longint TOPV = 65535;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [1:0] mode = 2'd0;
  logic [3:0] ewa_shift = '0, kp = '0, ki = '0, kd = '0;
  logic smp_valid = 1'b0, res_ready = 1'b1;
  logic [DW-1:0] smp_cycles = '0;
  logic smp_ready, res_valid, warmup;
  logic [DW-1:0] forecast;
  logic signed [DW:0] miss;

  int total = 0, bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  wl_predictor i_wl_predictor (
    .clk(clk), .rst(rst), .mode(mode), .ewa_shift(ewa_shift),
    .kp(kp), .ki(ki), .kd(kd), .smp_valid(smp_valid), .smp_ready(smp_ready),
    .smp_cycles(smp_cycles), .res_valid(res_valid), .res_ready(res_ready),
    .forecast(forecast), .miss(miss), .warmup(warmup)
  );

  task automatic chk(input string req, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // reference model
  longint est = 0;
  longint qa[$];
  longint qe[$];
  int nsamp = 0;

  function automatic longint clampv(input longint v);
    if (v < 0) return 0;
    if (v > TOPV) return TOPV;
    return v;
  endfunction

  task automatic model(input longint a, input int m, output longint p,
                       output longint e, output longint w);
    longint sum, isum, eold, d, nxt;
    int n;
    n = qe.size();
    e = a - est;
    qa.push_back(a);
    qe.push_back(e);
    sum = 0;
    for (int k = 0; k < N && k < qa.size(); k++) sum += qa[qa.size()-1-k];
    isum = 0;
    for (int k = 0; k < WI && k < qe.size(); k++) isum += qe[qe.size()-1-k];
    eold = (n >= WD) ? qe[qe.size()-1-WD] : 0;
    d = (e - eold) >>> LOG_WD;
    case (m)
      0: nxt = sum >>> LOG_N;
      1: nxt = est + (e >>> ewa_shift);
      default: nxt = est + longint'(kp) * e + longint'(ki) * (isum >>> LOG_WI)
                     + longint'(kd) * d;
    endcase
    p = clampv(nxt);
    est = p;
    nsamp++;
    w = (nsamp < ((m == 0) ? N : (m == 1) ? 1 : D)) ? 1 : 0;
    if (qa.size() > 16) void'(qa.pop_front());
    if (qe.size() > 16) void'(qe.pop_front());
  endtask

  task automatic send(input longint a, input int m, input string tag);
    longint p, e, w;
    @(negedge clk);
    mode = m[1:0];
    smp_cycles = a[DW-1:0];
    smp_valid = 1'b1;
    @(posedge clk);
    #1;
    smp_valid = 1'b0;
    model(a, m, p, e, w);
    chk(tag, longint'(forecast), p);
    chk("R3 miss", longint'(miss), e);
    chk("R8 warmup", longint'(warmup), w);
    chk("R2 res_valid", longint'(res_valid), 1);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    longint hold_p;
    void'($urandom(32'd4711));
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    #1;
    // R1
    chk("R1 forecast", longint'(forecast), 0);
    chk("R1 miss", longint'(miss), 0);
    chk("R1 res_valid", longint'(res_valid), 0);
    chk("R1 warmup", longint'(warmup), 1);
    chk("R1 smp_ready", longint'(smp_ready), 1);

    // R4 mean with zero-filled warm-up
    for (int i = 1; i <= 12; i++) send(i * 100, 0, "R4 mean");

    // R5 exponential, zero shift then shift of 2 on falling and rising input
    ewa_shift = 4'd0;
    send(5000, 1, "R5 exp shift0");
    send(123, 1, "R5 exp shift0");
    ewa_shift = 4'd2;
    for (int i = 0; i < 6; i++) send(7, 1, "R5 exp falling");
    for (int i = 0; i < 6; i++) send(40000, 1, "R5 exp rising");

    // R6 correction loop
    kp = 4'd1; ki = 4'd1; kd = 4'd1;
    for (int i = 0; i < 12; i++) send(1000 + i * 37, 2, "R6 loop");
    kp = 4'd2; ki = 4'd3; kd = 4'd2;
    for (int i = 0; i < 6; i++) send((i % 2) ? 3000 : 500, 3, "R6 loop alt");

    // R7 clamps
    kp = 4'd15; ki = 4'd15; kd = 4'd15;
    for (int i = 0; i < 4; i++) send(65535, 2, "R7 top clamp");
    for (int i = 0; i < 4; i++) send(0, 2, "R7 zero clamp");

    // R9 mode change uses full history
    kp = 4'd1; ki = 4'd0; kd = 4'd0;
    for (int i = 0; i < 5; i++) send(2000 + i, 2, "R9 before change");
    send(900, 0, "R9 mean after change");
    send(800, 0, "R9 mean after change");

    // R2 back-pressure
    @(negedge clk) res_ready = 1'b0;
    #1;
    chk("R2 smp_ready low", longint'(smp_ready), 0);
    hold_p = longint'(forecast);
    smp_cycles = 16'd12345;
    smp_valid = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    chk("R2 forecast held", longint'(forecast), hold_p);
    chk("R2 res_valid held", longint'(res_valid), 1);
    @(negedge clk);
    smp_valid = 1'b0;
    res_ready = 1'b1;
    @(posedge clk);
    #1;
    chk("R2 res_valid falls", longint'(res_valid), 0);
    chk("R2 forecast kept", longint'(forecast), hold_p);

    // seeded random mix
    for (int blk = 0; blk < 20; blk++) begin
      int m;
      kp = 4'($urandom_range(0, 15));
      ki = 4'($urandom_range(0, 15));
      kd = 4'($urandom_range(0, 15));
      ewa_shift = 4'($urandom_range(0, 7));
      m = $urandom_range(0, 3);
      for (int i = 0; i < 20; i++) begin
        longint a;
        a = longint'($urandom_range(0, 65535));
        send(a, m, (m == 0) ? "R4 random" : (m == 1) ? "R5 random" : "R6 random");
      end
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule